// File: doc/BRIEF.md
# Card Clock Divider with Odd Ratio Step

This block derives the card bus clock from the system bus clock with a programmable divider. Two modes are available. Legacy mode supports only even ratios, 2*(DIV+1). Extended mode adds a one-bit odd step, so the ratio is 2*DIV+ODD+2 and odd ratios are possible. For an odd ratio the high phase is one bus cycle shorter than the low phase, which keeps the duty cycle as close to even as the bus clock allows.

Alongside the card clock, the block outputs a single-cycle rise strobe and a single-cycle fall strobe. The command and data paths use these strobes to time their work on card clock edges. A new divider setting is taken up only when the card clock rises. The block reports the ratio that is actually in use, so software can see when a change has landed.

Clearing the power-save disable input lets the clock finish its current high phase and then park low. A synchronous soft reset returns the divider to its slowest default ratio.

Top module: `card_clk_div`

## Requirements
- R1: After asynchronous reset, card_clk_o, clk_rise_o and clk_fall_o are 0, and div_eff_o reads 2^(DIV_W+1), which is 512 with the default parameters.
- R2: With ext_mode_i = 0, the card clock period is 2*(div_i+1) bus cycles: 2 for div_i = 0 and 512 for div_i = 255.
- R3: With ext_mode_i = 1, the period is 2*div_i + odd_i + 2 bus cycles, ranging from 2 ({0,0}) to 513 ({255,1}).
- R4: In every period of N bus cycles, the card clock is high for floor(N/2) cycles and low for the remaining ceil(N/2) cycles.
- R5: div_i, odd_i and ext_mode_i are sampled only in the bus cycle where the card clock rises. A period that is already running keeps its length, and div_eff_o stays unchanged until that rise.
- R6: clk_rise_o is high for exactly the one bus cycle in which card_clk_o first reads 1. clk_fall_o is high for exactly the one cycle in which card_clk_o first reads 0 after a high phase.
- R7: odd_i has no effect in legacy mode.
- R8: While pwr_save_dis_i = 0, the card clock completes any high phase in progress and then stays low with no strobes. After pwr_save_dis_i returns to 1, the next rise comes after a full low phase of ceil(N/2) cycles.
- R9: A one-cycle sw_rst_i forces card_clk_o low and restores div_eff_o to the default. The next rise then follows after half the default ratio (256 cycles).
- R10: At each rise, div_eff_o reads the ratio N that governs the period starting there, and it always lies between 2 and 2^(DIV_W+1)+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_rst_i | input | 1 | Synchronous soft reset to the default ratio |
| div_i | input | DIV_W | Divider field |
| odd_i | input | 1 | Odd step, used in extended mode only |
| ext_mode_i | input | 1 | 0 = legacy even ratios, 1 = extended ratios |
| pwr_save_dis_i | input | 1 | 1 = clock runs, 0 = park low after the current high phase |
| card_clk_o | output | 1 | Card bus clock |
| clk_rise_o | output | 1 | One-cycle strobe on each card clock rise |
| clk_fall_o | output | 1 | One-cycle strobe on each card clock fall |
| div_eff_o | output | DIV_W+2 | Ratio currently applied, in bus cycles |

## Verification
Periods and high-phase lengths are measured for legacy and extended settings that span both ends of the range (ratios 2, 3, 512, 513) and a sweep of mixed odd and even values. Comparing the two mode formulas with the same divider separates a mix-up of the modes from an error in the odd step. A legacy setting with the odd bit set shows that the bit is ignored in that mode. A setting changed in the middle of a long period shows whether the change lands early or truncates the running period. Parking the clock, releasing it, and issuing a soft reset each measure the delay to the next rise, which shows whether the low-phase count restarts from zero.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  typedef enum logic {
    MODE_LEGACY = 1'b0,
    MODE_EXT    = 1'b1
  } ccd_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } ccd_edge_t;
endpackage

// File: rtl/ccd_ratio_calc.sv
module ccd_ratio_calc
  import ccd_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter bit EXT_EN  = 1'b1,
  parameter int RATIO_W = DIV_W + 2
) (
  input  logic [DIV_W-1:0]   div_i,
  input  logic               odd_i,
  input  ccd_mode_e          mode_i,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [RATIO_W-1:0] even_ratio;

  assign even_ratio = {1'b0, div_i, 1'b0} + RATIO_W'(2);

  generate
    if (EXT_EN) begin : g_ext
      logic [RATIO_W-1:0] odd_ratio;
      assign odd_ratio = {1'b0, div_i, odd_i} + RATIO_W'(2);
      assign ratio_o   = (mode_i == MODE_EXT) ? odd_ratio : even_ratio;
    end else begin : g_legacy_only
      logic unused_sel;
      assign unused_sel = odd_i ^ mode_i;
      assign ratio_o    = even_ratio;
    end
  endgenerate
endmodule

// File: rtl/ccd_phase_gen.sv
module ccd_phase_gen
  import ccd_pkg::*;
#(
  parameter int RATIO_W   = 10,
  parameter int DEF_RATIO = 512
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_rst_i,
  input  logic               run_i,
  input  logic [RATIO_W-1:0] ratio_new_i,
  output logic               card_clk_o,
  output ccd_edge_t          edge_o,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam int CNT_W = RATIO_W - 1;

  logic [RATIO_W-1:0] ratio_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               clk_q;
  ccd_edge_t          edge_q;

  logic [CNT_W-1:0] hi_len, lo_len, cur_len;
  logic             phase_end;

  // odd ratios: high phase is the shorter half
  assign hi_len    = ratio_q[RATIO_W-1:1];
  assign lo_len    = CNT_W'(ratio_q - RATIO_W'(hi_len));
  assign cur_len   = clk_q ? hi_len : lo_len;
  assign phase_end = (cnt_q == cur_len - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= RATIO_W'(DEF_RATIO);
      cnt_q   <= '0;
      clk_q   <= 1'b0;
      edge_q  <= '0;
    end else if (sw_rst_i) begin
      ratio_q <= RATIO_W'(DEF_RATIO);
      cnt_q   <= '0;
      clk_q   <= 1'b0;
      edge_q  <= '0;
    end else begin
      edge_q <= '0;
      if (!clk_q && !run_i) begin
        cnt_q <= '0;
      end else if (phase_end) begin
        cnt_q <= '0;
        clk_q <= ~clk_q;
        if (!clk_q) begin
          edge_q.rise <= 1'b1;
          ratio_q     <= ratio_new_i;
        end else begin
          edge_q.fall <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign card_clk_o = clk_q;
  assign edge_o     = edge_q;
  assign ratio_o    = ratio_q;
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import ccd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter bit EXT_EN = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sw_rst_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               odd_i,
  input  logic               ext_mode_i,
  input  logic               pwr_save_dis_i,
  output logic               card_clk_o,
  output logic               clk_rise_o,
  output logic               clk_fall_o,
  output logic [DIV_W+1:0]   div_eff_o
);
  localparam int RATIO_W   = DIV_W + 2;
  localparam int DEF_RATIO = 2 ** (DIV_W + 1);

  ccd_mode_e          mode_sel;
  logic [RATIO_W-1:0] ratio_new;
  ccd_edge_t          edges;

  assign mode_sel = ext_mode_i ? MODE_EXT : MODE_LEGACY;

  ccd_ratio_calc #(
    .DIV_W  (DIV_W),
    .EXT_EN (EXT_EN),
    .RATIO_W(RATIO_W)
  ) u_ratio (
    .div_i  (div_i),
    .odd_i  (odd_i),
    .mode_i (mode_sel),
    .ratio_o(ratio_new)
  );

  ccd_phase_gen #(
    .RATIO_W  (RATIO_W),
    .DEF_RATIO(DEF_RATIO)
  ) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_rst_i   (sw_rst_i),
    .run_i      (pwr_save_dis_i),
    .ratio_new_i(ratio_new),
    .card_clk_o (card_clk_o),
    .edge_o     (edges),
    .ratio_o    (div_eff_o)
  );

  assign clk_rise_o = edges.rise;
  assign clk_fall_o = edges.fall;
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk #(
  parameter int RATIO_W   = 10,
  parameter int DEF_RATIO = 512
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sw_rst_i,
  input logic               pwr_save_dis_i,
  input logic               card_clk_o,
  input logic               clk_rise_o,
  input logic               clk_fall_o,
  input logic [RATIO_W-1:0] div_eff_o
);
  localparam int MAX_RATIO = 2 ** (RATIO_W - 1) + 1;

  p_rise_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_rise_o |-> (card_clk_o && !$past(card_clk_o)));

  p_rise_cover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_clk_o && !$past(card_clk_o)) |-> clk_rise_o);

  p_fall_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_fall_o |-> (!card_clk_o && $past(card_clk_o)));

  p_fall_cover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!card_clk_o && $past(card_clk_o) && !$past(sw_rst_i)) |-> clk_fall_o);

  p_eff_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_rise_o && !$past(sw_rst_i)) |-> $stable(div_eff_o));

  p_park_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(pwr_save_dis_i) && !$past(card_clk_o)) |-> !card_clk_o);

  p_sw_default_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sw_rst_i) |-> (!card_clk_o && div_eff_o == RATIO_W'(DEF_RATIO)));

  p_eff_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_eff_o >= RATIO_W'(2)) && (div_eff_o <= RATIO_W'(MAX_RATIO)));
endmodule

bind card_clk_div card_clk_div_chk #(
  .RATIO_W  (RATIO_W),
  .DEF_RATIO(DEF_RATIO)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sw_rst_i      (sw_rst_i),
  .pwr_save_dis_i(pwr_save_dis_i),
  .card_clk_o    (card_clk_o),
  .clk_rise_o    (clk_rise_o),
  .clk_fall_o    (clk_fall_o),
  .div_eff_o     (div_eff_o)
);

// File: tb/sim_card_clk_div.sv
`timescale 1ns/1ps
module sim_card_clk_div;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sw_rst = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic             odd = 1'b0;
  logic             ext = 1'b0;
  logic             run = 1'b1;
  logic             card_clk, rise, fall;
  logic [DIV_W+1:0] div_eff;

  int n_chk = 0;
  int n_err = 0;
  int exp_q[$];
  string tag_q[$];
  int per_cnt = 0;
  int hi_cnt = 0;
  bit meas_valid = 1'b0;

  always #4 clk = ~clk;

  card_clk_div #(.DIV_W(DIV_W), .EXT_EN(1'b1)) u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .sw_rst_i      (sw_rst),
    .div_i         (div),
    .odd_i         (odd),
    .ext_mode_i    (ext),
    .pwr_save_dis_i(run),
    .card_clk_o    (card_clk),
    .clk_rise_o    (rise),
    .clk_fall_o    (fall),
    .div_eff_o     (div_eff)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: measure rise-to-rise period and high length, compare with scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rise) begin
        if (meas_valid && exp_q.size() > 0) begin
          int n;
          string t;
          n = exp_q.pop_front();
          t = tag_q.pop_front();
          check(per_cnt == n, {t, " period"}, per_cnt, n);
          check(hi_cnt == n / 2, {"R4 high phase (", t, ")"}, hi_cnt, n / 2);
        end
        per_cnt    = 1;
        hi_cnt     = 1;
        meas_valid = 1'b1;
      end else begin
        per_cnt++;
        if (card_clk) hi_cnt++;
      end
    end else begin
      meas_valid = 1'b0;
    end
  end

  // driver: apply setting, wait for the rise that takes it, push the expected period
  task automatic run_cfg(input int d, input bit o, input bit e, input string tag);
    int n;
    div = DIV_W'(d);
    odd = o;
    ext = e;
    n = e ? (2 * d + int'(o) + 2) : (2 * d + 2);
    do @(negedge clk); while (!rise);
    #1;
    exp_q.push_back(n);
    tag_q.push_back(tag);
    check(int'(div_eff) == n, "R10 readback at rise", int'(div_eff), n);
  endtask

  task automatic flush();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    check(card_clk == 1'b0, "R1 clock in reset", int'(card_clk), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(card_clk == 1'b0 && rise == 1'b0 && fall == 1'b0, "R1 outputs after reset",
          int'({card_clk, rise, fall}), 0);
    check(int'(div_eff) == 512, "R1 default ratio", int'(div_eff), 512);

    // legacy mode
    run_cfg(0, 1'b0, 1'b0, "R2");
    run_cfg(1, 1'b0, 1'b0, "R2");
    run_cfg(3, 1'b1, 1'b0, "R7");
    run_cfg(7, 1'b0, 1'b0, "R2");
    run_cfg(100, 1'b0, 1'b0, "R2");
    run_cfg(255, 1'b0, 1'b0, "R2");
    run_cfg(255, 1'b1, 1'b0, "R7");
    // extended mode
    run_cfg(0, 1'b0, 1'b1, "R3");
    run_cfg(0, 1'b1, 1'b1, "R3");
    run_cfg(1, 1'b1, 1'b1, "R3");
    run_cfg(2, 1'b0, 1'b1, "R3");
    run_cfg(255, 1'b1, 1'b1, "R3");
    run_cfg(255, 1'b0, 1'b1, "R3");
    for (int i = 0; i < 16; i++) run_cfg((i * 37 + 5) % 256, 1'(i), 1'b1, "R3");
    run_cfg(3, 1'b1, 1'b1, "R3");
    run_cfg(3, 1'b1, 1'b0, "R7");

    // R5: change in the middle of a long period
    run_cfg(20, 1'b0, 1'b1, "R5");
    div = 8'd1; odd = 1'b0; ext = 1'b0;
    repeat (10) @(negedge clk);
    check(int'(div_eff) == 42, "R5 readback mid-period", int'(div_eff), 42);
    run_cfg(1, 1'b0, 1'b0, "R5");
    run_cfg(4, 1'b0, 1'b0, "R2");
    flush();

    // R8: park and release
    do @(negedge clk); while (!rise);
    run = 1'b0;
    k = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (rise) k++;
    end
    check(k == 0, "R8 rises while parked", k, 0);
    check(card_clk == 1'b0, "R8 parked level", int'(card_clk), 0);
    run = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!rise && k < 1000);
    check(k == 5, "R8 release to rise", k, 5);

    // R9: soft reset
    do @(negedge clk); while (!card_clk);
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    check(card_clk == 1'b0, "R9 clock after soft reset", int'(card_clk), 0);
    check(int'(div_eff) == 512, "R9 default ratio", int'(div_eff), 512);
    k = 0;
    do begin @(negedge clk); k++; end while (!rise && k < 1000);
    check(k == 256, "R9 first rise delay", k, 256);
    check(int'(div_eff) == 10, "R10 readback after soft reset", int'(div_eff), 10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule